// File: doc/BRIEF.md
# Fast A20 Gate and CPU Reset Decoder

This block sits beside a keyboard-controller style port pair and snoops every host write. A select input tells command-port writes from data-port writes. Two short command patterns are serviced directly in hardware. The first is a gate-update sequence: an arm command, then one data byte whose bit 1 becomes the new A20 gate level, then a closing command. The second is a reset command that produces a timed, delayed pulse on the CPU reset output. Bytes that belong to a recognised pattern are absorbed, and the input-buffer-full flag stays low for them.

Every other byte raises the input-buffer-full flag so that the keyboard firmware picks it up. The firmware clears the flag with an acknowledge strobe. Each of the two outputs has its own polarity-inversion configuration bit. The reset delay and width are given in nanoseconds and turned into cycle counts from the clock frequency. Both counts are rounded up, so the minimum times always hold.

Top module: `fastGateReset`

## Requirements
- R1: While reset is held and just after it, the flag is 0, the gate is at its inactive level (internal gate state 0), and the CPU reset output is deasserted.
- R2: A command write (cmdSel=1) of 0xD1 followed by a data write (cmdSel=0) loads data bit 1 into the gate state. The other seven data bits have no effect. The flag stays 0 for the 0xD1, the data byte and the closing 0xFF.
- R3: The gate output keeps its value across the 0xD1 write and across the closing 0xFF write.
- R4: Several 0xD1 command writes before the data byte are accepted with the flag at 0, and the sequence then completes normally.
- R5: After 0xD1, any command byte other than 0xD1 sets the flag. The following 0xFF also sets the flag, and the gate state is left unchanged. A 0xFE in that position starts no reset pulse.
- R6: A second data byte after the gate data byte sets the flag, does not change the gate, and returns the decoder to idle.
- R7: In idle, a 0xFE command leaves the flag at 0 and starts a reset pulse. The pulse is asserted DELAY_CYC cycles after the write edge and lasts exactly WIDTH_CYC cycles. Each count is the ceiling of frequency × time (14000 ns and 6000 ns by default).
- R8: A 0xFE that arrives while a pulse is pending or active leaves the flag at 0 and does not restart or stretch the timing.
- R9: gatePolInv=1 inverts gateOut. resetPolInv=0 makes the reset output active-low, and resetPolInv=1 makes it active-high.
- R10: In idle, any data write and any command byte other than 0xD1 and 0xFE sets the flag.
- R11: ibfAck clears the flag. If a byte sets the flag in the same cycle as ibfAck, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle host write strobe |
| cmdSel | input | 1 | 1 = command port, 0 = data port |
| wrData | input | 8 | Written byte |
| gatePolInv | input | 1 | Inverts gateOut |
| resetPolInv | input | 1 | Inverts cpuResetOut |
| ibfAck | input | 1 | Firmware read acknowledge, clears the flag |
| gateOut | output | 1 | A20 gate output |
| cpuResetOut | output | 1 | CPU reset output, active-low by default |
| ibfFlag | output | 1 | Input buffer full flag |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a flag-setting byte and the firmware acknowledge. The bench drives both in one cycle and expects the flag to read 1 afterwards. The second pair is a gate-update sequence and a running reset pulse. The bench writes 0xD1, a data byte and 0xFF inside the pulse window. It then confirms that the pulse edges still fall on the computed cycles and that the gate takes the new level.

// File: rtl/fgrPkg.sv
package fgrPkg;
  typedef struct packed {
    logic loadGate;
    logic setIbf;
    logic startReset;
  } ctlStrobes_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARMED, SEQ_DONE, SEQ_BAD} seqState_t;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_PULSE} rstPhase_t;
endpackage

// File: rtl/fgrControl.sv
module fgrControl import fgrPkg::*; #(
  parameter logic [7:0] CMD_ARM   = 8'hD1,
  parameter logic [7:0] CMD_CLOSE = 8'hFF,
  parameter logic [7:0] CMD_RESET = 8'hFE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic        cmdSel,
  input  logic [7:0]  wrData,
  output ctlStrobes_t strobes
);
  seqState_t state, nextState;
  logic isArm, isClose, isReset;

  assign isArm   = cmdSel && (wrData == CMD_ARM);
  assign isClose = cmdSel && (wrData == CMD_CLOSE);
  assign isReset = cmdSel && (wrData == CMD_RESET);

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (wrStrobe) begin
      unique case (state)
        SEQ_IDLE: begin
          if (isArm)        nextState = SEQ_ARMED;
          else if (isReset) strobes.startReset = 1'b1;
          else              strobes.setIbf = 1'b1;
        end
        SEQ_ARMED: begin
          if (!cmdSel) begin
            strobes.loadGate = 1'b1;
            nextState = SEQ_DONE;
          end else if (!isArm) begin
            strobes.setIbf = 1'b1;
            nextState = SEQ_BAD;
          end
        end
        SEQ_DONE: begin
          if (!isClose) strobes.setIbf = 1'b1;
          nextState = SEQ_IDLE;
        end
        SEQ_BAD: begin
          strobes.setIbf = 1'b1;
          if (isClose) nextState = SEQ_IDLE;
        end
        default: nextState = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  // R6: an extra data byte after the gate byte ends the sequence
  p_extra_data_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_DONE && wrStrobe && !cmdSel) |=> (state == SEQ_IDLE));

  // R2: at most one action per write
  p_single_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadGate, strobes.setIbf, strobes.startReset}));
endmodule

// File: rtl/fgrDatapath.sv
module fgrDatapath import fgrPkg::*; #(
  parameter int DELAY_CYC = 1400,
  parameter int WIDTH_CYC = 600
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        dataBit,
  input  logic        gatePolInv,
  input  logic        resetPolInv,
  input  logic        ibfAck,
  output logic        gateOut,
  output logic        cpuResetOut,
  output logic        ibfFlag
);
  localparam int MAX_CYC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] WIDTH_LAST = CNT_W'(WIDTH_CYC - 1);

  rstPhase_t phase;
  logic [CNT_W-1:0] cnt;
  logic gateState, ibfReg, rstActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateState <= 1'b0;
      ibfReg    <= 1'b0;
    end else begin
      if (strobes.loadGate) gateState <= dataBit;
      if (strobes.setIbf)   ibfReg <= 1'b1;
      else if (ibfAck)      ibfReg <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (strobes.startReset) begin
          phase <= PH_WAIT;
          cnt   <= '0;
        end
        PH_WAIT: if (cnt == DELAY_LAST) begin
          phase <= PH_PULSE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_PULSE: if (cnt == WIDTH_LAST) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign rstActive   = (phase == PH_PULSE);
  assign gateOut     = gateState ^ gatePolInv;
  assign cpuResetOut = ~rstActive ^ resetPolInv;
  assign ibfFlag     = ibfReg;

  logic [CNT_W:0] seenLen;
  always_ff @(posedge clk) begin
    if (!rstN || !rstActive) seenLen <= '0;
    else                     seenLen <= seenLen + 1'b1;
  end

  // R7: every pulse lasts exactly WIDTH_CYC cycles
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> (seenLen == (CNT_W+1)'(WIDTH_CYC)));

  // R8: a reset command while waiting keeps the count running
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && strobes.startReset && cnt != DELAY_LAST)
      |=> (phase == PH_WAIT && cnt == $past(cnt) + 1'b1));

  // R11: acknowledge without a new set clears the flag
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ibfAck && !strobes.setIbf) |=> !ibfFlag);

  // R10: a set request always shows on the flag
  p_set_visible_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setIbf |=> ibfFlag);
endmodule

// File: rtl/fastGateReset.sv
module fastGateReset import fgrPkg::*; #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned DELAY_NS = 14_000,
  parameter int unsigned WIDTH_NS = 6_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStrobe,
  input  logic       cmdSel,
  input  logic [7:0] wrData,
  input  logic       gatePolInv,
  input  logic       resetPolInv,
  input  logic       ibfAck,
  output logic       gateOut,
  output logic       cpuResetOut,
  output logic       ibfFlag
);
  localparam longint NS_PER_S  = 64'd1_000_000_000;
  localparam longint DELAY_L   = (longint'(CLK_HZ) * longint'(DELAY_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam longint WIDTH_L   = (longint'(CLK_HZ) * longint'(WIDTH_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam int     DELAY_CYC = (DELAY_L < 1) ? 1 : int'(DELAY_L);
  localparam int     WIDTH_CYC = (WIDTH_L < 1) ? 1 : int'(WIDTH_L);

  ctlStrobes_t strobes;

  fgrControl uCtl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .cmdSel(cmdSel),
    .wrData(wrData), .strobes(strobes)
  );

  fgrDatapath #(.DELAY_CYC(DELAY_CYC), .WIDTH_CYC(WIDTH_CYC)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(wrData[1]),
    .gatePolInv(gatePolInv), .resetPolInv(resetPolInv), .ibfAck(ibfAck),
    .gateOut(gateOut), .cpuResetOut(cpuResetOut), .ibfFlag(ibfFlag)
  );

  // R3: command writes never move the gate
  p_gate_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrStrobe && !cmdSel) ##1 $stable(gatePolInv)) |-> $stable(gateOut));
endmodule

// File: tb/fastGateReset_test.sv
module fastGateReset_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrStrobe, cmdSel, gatePolInv, resetPolInv, ibfAck;
  logic [7:0] wrData;
  logic gateOut, cpuResetOut, ibfFlag;

  fastGateReset uut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .cmdSel(cmdSel), .wrData(wrData),
    .gatePolInv(gatePolInv), .resetPolInv(resetPolInv), .ibfAck(ibfAck),
    .gateOut(gateOut), .cpuResetOut(cpuResetOut), .ibfFlag(ibfFlag)
  );

  localparam longint EXP_D = (64'd100_000_000 * 64'd14_000 + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint EXP_W = (64'd100_000_000 * 64'd6_000 + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int expDelay = int'(EXP_D);
  localparam int expWidth = int'(EXP_W);

  int checks = 0, errors = 0;
  logic expGate = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic c, logic [7:0] d);
    wrStrobe = 1'b1; cmdSel = c; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0; cmdSel = 1'b0; wrData = 8'h00;
  endtask

  task automatic ack();
    ibfAck = 1'b1;
    @(negedge clk);
    ibfAck = 1'b0;
  endtask

  // called right after a 0xFE write; j counts edges since that write
  task automatic measure(string req, int at[3], logic c[3], logic [7:0] d[3]);
    int bad = 0;
    for (int j = 0; j < expDelay + expWidth + 4; j++) begin
      logic act, expOut;
      act = (j >= expDelay) && (j < expDelay + expWidth);
      expOut = ~act ^ resetPolInv;
      if (cpuResetOut !== expOut) bad++;
      wrStrobe = 1'b0; cmdSel = 1'b0; wrData = 8'h00;
      for (int k = 0; k < 3; k++)
        if (j == at[k]) begin wrStrobe = 1'b1; cmdSel = c[k]; wrData = d[k]; end
      @(negedge clk);
    end
    wrStrobe = 1'b0; cmdSel = 1'b0; wrData = 8'h00;
    check({req, " pulse timing mismatches"}, bad, 0);
    check({req, " flag"}, ibfFlag, 0);
  endtask

  initial begin
    #1_500_000ns;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int none[3] = '{-1, -1, -1};
    logic cz[3] = '{1'b0, 1'b0, 1'b0};
    logic [7:0] dz[3] = '{8'h00, 8'h00, 8'h00};
    logic [7:0] bads[5] = '{8'h00, 8'hFE, 8'hFF, 8'h60, 8'hD0};

    rstN = 1'b0; wrStrobe = 1'b0; cmdSel = 1'b0; wrData = 8'h00;
    gatePolInv = 1'b0; resetPolInv = 1'b0; ibfAck = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 gate in reset", gateOut, 0);
    check("R1 reset out in reset", cpuResetOut, 1);
    check("R1 flag in reset", ibfFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 gate after reset", gateOut, 0);
    gatePolInv = 1'b1; resetPolInv = 1'b1; #1;
    check("R9 gate inverted", gateOut, 1);
    check("R9 reset inverted idle", cpuResetOut, 0);
    gatePolInv = 1'b0; resetPolInv = 1'b0;

    // R2 R3 R4 sweep of every data byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v);
      gatePolInv = d[0];
      wr(1'b1, 8'hD1);
      check("R3 gate held on arm", gateOut, expGate ^ d[0]);
      check("R2 flag after arm", ibfFlag, 0);
      if (v % 4 == 0) begin
        wr(1'b1, 8'hD1);
        check("R4 flag after repeated arm", ibfFlag, 0);
      end
      wr(1'b0, d);
      expGate = d[1];
      check("R2 gate loaded from bit 1", gateOut, expGate ^ d[0]);
      check("R2 flag after data", ibfFlag, 0);
      wr(1'b1, 8'hFF);
      check("R3 gate held on close", gateOut, expGate ^ d[0]);
      check("R2 flag after close", ibfFlag, 0);
    end
    gatePolInv = 1'b0;

    // R10 unrecognised bytes in idle
    for (int v = 0; v < 256; v++) begin
      if (v != 8'hD1 && v != 8'hFE) begin
        wr(1'b1, 8'(v));
        check("R10 flag on other command", ibfFlag, 1);
        ack();
        check("R11 flag cleared", ibfFlag, 0);
      end
    end
    for (int v = 0; v < 256; v += 37) begin
      wr(1'b0, 8'(v));
      check("R10 flag on idle data", ibfFlag, 1);
      check("R10 gate untouched", gateOut, expGate);
      ack();
    end

    // R11 set and acknowledge in the same cycle
    ibfAck = 1'b1;
    wr(1'b0, 8'h55);
    ibfAck = 1'b0;
    check("R11 set wins over ack", ibfFlag, 1);
    ack();
    check("R11 ack alone clears", ibfFlag, 0);

    // R5 invalid sequences
    foreach (bads[i]) begin
      wr(1'b1, 8'hD1);
      wr(1'b1, bads[i]);
      check("R5 flag on bad command", ibfFlag, 1);
      check("R5 gate unchanged", gateOut, expGate);
      ack();
      if (bads[i] == 8'hFE) begin
        repeat (expDelay + 5) @(negedge clk);
        check("R5 no pulse from bad 0xFE", cpuResetOut, 1);
      end
      wr(1'b1, 8'hFF);
      check("R5 flag on following close", ibfFlag, 1);
      check("R5 gate unchanged after close", gateOut, expGate);
      ack();
    end

    // R6 second data byte
    wr(1'b1, 8'hD1);
    wr(1'b0, 8'h02);
    check("R6 first data applied", gateOut, 1);
    wr(1'b0, 8'h00);
    check("R6 flag on second data", ibfFlag, 1);
    check("R6 gate keeps first value", gateOut, 1);
    ack();
    wr(1'b0, 8'h00);
    check("R6 back in idle, data flagged", ibfFlag, 1);
    ack();
    wr(1'b1, 8'hD1); wr(1'b0, 8'h00); wr(1'b1, 8'hFF);
    check("R6 new sequence works", gateOut, 0);
    check("R6 new sequence flag", ibfFlag, 0);
    expGate = 1'b0;

    // R7 plain pulse
    wr(1'b1, 8'hFE);
    check("R7 flag after reset command", ibfFlag, 0);
    measure("R7", none, cz, dz);

    // R8 repeated 0xFE while pending and while active
    wr(1'b1, 8'hFE);
    measure("R8", '{500, expDelay + 100, -1}, '{1'b1, 1'b1, 1'b0},
            '{8'hFE, 8'hFE, 8'h00});

    // R9 active-high reset pulse
    resetPolInv = 1'b1;
    wr(1'b1, 8'hFE);
    measure("R9", none, cz, dz);
    resetPolInv = 1'b0;

    // R2 gate sequence inside a running pulse
    wr(1'b1, 8'hFE);
    measure("R2 with pulse", '{expDelay + 5, expDelay + 7, expDelay + 9},
            '{1'b1, 1'b0, 1'b1}, '{8'hD1, 8'hFD, 8'hFF});
    check("R2 gate set during pulse", gateOut, 0);
    wr(1'b1, 8'hFE);
    measure("R2 with pulse b", '{expDelay + 5, expDelay + 7, expDelay + 9},
            '{1'b1, 1'b0, 1'b1}, '{8'hD1, 8'h02, 8'hFF});
    check("R2 gate set during pulse b", gateOut, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule